// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Controller

This block tracks fixed-mode interrupt vectors for one processor core. It keeps three 256-entry bitmaps:

- **pending**: vectors that have been requested.
- **in-service**: vectors that have been acknowledged and not yet retired.
- **trigger**: one bit per vector, the trigger mode (level or edge) recorded when the vector was last accepted.

An 8-bit task priority, written by software, sets a floor for delivery. The block combines it with the priority class of the highest vector in service to form the processor priority.

The highest pending vector is offered to the core only when its class is strictly above that processor priority. The core accepts the offered vector with an acknowledge strobe, which moves it from pending to in service. The core retires the highest in-service vector with an end-of-interrupt strobe. This produces a one-cycle broadcast carrying the retired vector and its latched trigger mode, which lets an upstream level-triggered source rearm. A directed-EOI enable input suppresses the broadcast.

A global enable gates both the acceptance of new requests and the delivery of pending vectors. An active-low asynchronous reset clears all state.

Top module: `ipac_ctrl`

## Requirements
- R1: A request accepted at a clock edge sets the vector's pending bit. It also writes the vector's trigger bit: 1 when `req_level_i` is 1 (level), 0 when it is 0 (edge). `req_accepted_o` is combinational and reports acceptance in the cycle of the request.
- R2: A request for a vector whose pending bit is already set drives `req_accepted_o` low. Pending, in-service and trigger state stay unchanged.
- R3: The processor priority `ppr_o` is computed from the task priority T and the highest in-service vector S, where S is 0 when nothing is in service:
  - when T[7:4] >= S[7:4], `ppr_o` equals T;
  - otherwise `ppr_o` equals S & 8'hF0.
- R4: `irq_valid_o` is high only when the highest-numbered pending vector P satisfies (P & 8'hF0) > `ppr_o`. `irq_vec_o` then equals P.
- R5: `ack_i` sampled high while `irq_valid_o` is high does three things at that edge: it sets the in-service bit of `irq_vec_o`, clears that vector's pending bit, and `ppr_o` reflects the new in-service set from the next cycle.
- R6: `eoi_i` clears the highest in-service bit, and `ppr_o` is recomputed. With nothing in service, `eoi_i` changes nothing and produces no broadcast.
- R7: A retiring `eoi_i` raises `eoi_bcast_o` for exactly the next cycle. In that cycle `eoi_vec_o` is the retired vector and `eoi_level_o` is its trigger bit. No broadcast is produced when `directed_eoi_i` is 1.
- R8: A task-priority write (`tpr_wr_i`) keeps bits [7:0] of `tpr_data_i`. An alias write (`tpr_alias_wr_i`) sets T[7:4] to the 4-bit value and T[3:0] to 0. `tpr_wr_i` wins when both are high. `tpr_class_o` always shows T[7:4].
- R9: While `enable_i` is 0, requests are dropped and `irq_valid_o` is low. Reset clears all three bitmaps and the task priority.
- R10: When a request and an acknowledge fall in the same cycle, the acknowledge acts on the state from before that cycle. The new request becomes deliverable from the next cycle.
- R11: `ack_i` while `irq_valid_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Requested vector |
| req_level_i | input | 1 | Trigger mode of the request: 1 level, 0 edge |
| req_accepted_o | output | 1 | Request accepted this cycle |
| tpr_wr_i | input | 1 | Task-priority write strobe |
| tpr_data_i | input | 32 | Task-priority write data; only [7:0] is kept |
| tpr_alias_wr_i | input | 1 | 4-bit alias write strobe |
| tpr_alias_i | input | 4 | Alias value, placed in task priority [7:4] |
| tpr_o | output | 8 | Task priority |
| tpr_class_o | output | 4 | Task priority [7:4] (alias read) |
| ack_i | input | 1 | Acknowledge of the offered vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| directed_eoi_i | input | 1 | Suppresses the EOI broadcast |
| irq_valid_o | output | 1 | A vector is deliverable |
| irq_vec_o | output | 8 | Deliverable vector |
| ppr_o | output | 8 | Processor priority |
| eoi_bcast_o | output | 1 | EOI broadcast pulse |
| eoi_vec_o | output | 8 | Retired vector |
| eoi_level_o | output | 1 | Trigger mode of the retired vector |

## Verification
`req_accepted_o` depends on the current pending state and is due in the cycle of the request. The bench samples it one time unit after driving the request, before the edge.

Pending, in-service and task-priority updates, and therefore `irq_valid_o`, `irq_vec_o` and `ppr_o`, become visible after one clock edge. The EOI broadcast is registered and appears for the single cycle after the strobe.

The bench drives all inputs at the falling edge. It checks registered results at the next falling edge, so every check sits in the cycle its value is due. Same-cycle request plus acknowledge, and the strobes that should change nothing, are checked at the same point.

// File: rtl/ipac_pkg.sv
package ipac_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLASS_W = 4;
  localparam int DATA_W  = 32;
endpackage

// File: rtl/ipac_prio_enc.sv
// Highest-set-bit encoder over N inputs.
module ipac_prio_enc #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (bits_i[i]) begin
        idx_o   = IW'(i);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipac_bitmap.sv
// N-bit state vector with one indexed set and one indexed clear per cycle.
module ipac_bitmap #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_en_i,
  input  logic [IW-1:0] set_idx_i,
  input  logic          clr_en_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [N-1:0]  bits_o
);
  logic [N-1:0] set_mask, clr_mask, bits_q;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (set_en_i) set_mask[set_idx_i] = 1'b1;
    if (clr_en_i) clr_mask[clr_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= (bits_q | set_mask) & ~clr_mask;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/ipac_prio_calc.sv
// Processor priority from task priority and top in-service vector.
module ipac_prio_calc #(
  parameter int VW = 8,
  parameter int CW = 4
) (
  input  logic [VW-1:0] tpr_i,
  input  logic [VW-1:0] isr_top_i,
  input  logic          isr_any_i,
  output logic [VW-1:0] ppr_o
);
  localparam logic [VW-1:0] CLS_MASK = {{CW{1'b1}}, {(VW-CW){1'b0}}};

  logic [VW-1:0] isr_v;

  always_comb begin
    isr_v = isr_any_i ? isr_top_i : '0;
    if (tpr_i[VW-1 -: CW] >= isr_v[VW-1 -: CW]) ppr_o = tpr_i;
    else                                         ppr_o = isr_v & CLS_MASK;
  end
endmodule

// File: rtl/ipac_ctrl.sv
module ipac_ctrl
  import ipac_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int N  = NUM_VEC,
  parameter int CW = CLASS_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          req_valid_i,
  input  logic [VW-1:0] req_vec_i,
  input  logic          req_level_i,
  output logic          req_accepted_o,
  input  logic          tpr_wr_i,
  input  logic [DW-1:0] tpr_data_i,
  input  logic          tpr_alias_wr_i,
  input  logic [CW-1:0] tpr_alias_i,
  output logic [VW-1:0] tpr_o,
  output logic [CW-1:0] tpr_class_o,
  input  logic          ack_i,
  input  logic          eoi_i,
  input  logic          directed_eoi_i,
  output logic          irq_valid_o,
  output logic [VW-1:0] irq_vec_o,
  output logic [VW-1:0] ppr_o,
  output logic          eoi_bcast_o,
  output logic [VW-1:0] eoi_vec_o,
  output logic          eoi_level_o
);
  localparam logic [VW-1:0] CLS_MASK = {{CW{1'b1}}, {(VW-CW){1'b0}}};

  logic [N-1:0]  irr_q, isr_q, tmr_q;
  logic [VW-1:0] irr_top, isr_top, ppr;
  logic          irr_any, isr_any;
  logic          req_ok, deliver, ack_fire, eoi_fire;
  logic [VW-1:0] tpr_q;
  logic          bcast_q, blevel_q;
  logic [VW-1:0] bvec_q;
  logic          unused_tpr_hi;

  assign unused_tpr_hi = ^tpr_data_i[DW-1:VW];

  assign req_ok   = enable_i & req_valid_i & ~irr_q[req_vec_i];
  assign deliver  = enable_i & irr_any & ((irr_top & CLS_MASK) > ppr);
  assign ack_fire = ack_i & deliver;
  assign eoi_fire = eoi_i & isr_any;

  ipac_prio_enc #(.N(N), .IW(VW)) u_irr_enc (
    .bits_i(irr_q), .idx_o(irr_top), .valid_o(irr_any));

  ipac_prio_enc #(.N(N), .IW(VW)) u_isr_enc (
    .bits_i(isr_q), .idx_o(isr_top), .valid_o(isr_any));

  ipac_bitmap #(.N(N), .IW(VW)) u_irr (
    .clk_i, .rst_ni,
    .set_en_i(req_ok),   .set_idx_i(req_vec_i),
    .clr_en_i(ack_fire), .clr_idx_i(irr_top),
    .bits_o(irr_q));

  ipac_bitmap #(.N(N), .IW(VW)) u_isr (
    .clk_i, .rst_ni,
    .set_en_i(ack_fire), .set_idx_i(irr_top),
    .clr_en_i(eoi_fire), .clr_idx_i(isr_top),
    .bits_o(isr_q));

  ipac_bitmap #(.N(N), .IW(VW)) u_tmr (
    .clk_i, .rst_ni,
    .set_en_i(req_ok & req_level_i),  .set_idx_i(req_vec_i),
    .clr_en_i(req_ok & ~req_level_i), .clr_idx_i(req_vec_i),
    .bits_o(tmr_q));

  ipac_prio_calc #(.VW(VW), .CW(CW)) u_ppr (
    .tpr_i(tpr_q), .isr_top_i(isr_top), .isr_any_i(isr_any), .ppr_o(ppr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             tpr_q <= '0;
    else if (tpr_wr_i)       tpr_q <= tpr_data_i[VW-1:0];
    else if (tpr_alias_wr_i) tpr_q <= {tpr_alias_i, {(VW-CW){1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcast_q  <= 1'b0;
      bvec_q   <= '0;
      blevel_q <= 1'b0;
    end else begin
      bcast_q <= eoi_fire & ~directed_eoi_i;
      if (eoi_fire) begin
        bvec_q   <= isr_top;
        blevel_q <= tmr_q[isr_top];
      end
    end
  end

  assign req_accepted_o = req_ok;
  assign tpr_o          = tpr_q;
  assign tpr_class_o    = tpr_q[VW-1 -: CW];
  assign irq_valid_o    = deliver;
  assign irq_vec_o      = irr_top;
  assign ppr_o          = ppr;
  assign eoi_bcast_o    = bcast_q;
  assign eoi_vec_o      = bvec_q;
  assign eoi_level_o    = blevel_q;
endmodule

// File: rtl/ipac_ctrl_chk.sv
module ipac_ctrl_chk #(
  parameter int VW = 8,
  parameter int N  = 256
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          req_valid_i,
  input logic [VW-1:0] req_vec_i,
  input logic          req_level_i,
  input logic          req_accepted_o,
  input logic          tpr_wr_i,
  input logic          tpr_alias_wr_i,
  input logic [VW-1:0] tpr_o,
  input logic          ack_i,
  input logic          eoi_i,
  input logic          directed_eoi_i,
  input logic          irq_valid_o,
  input logic [VW-1:0] irq_vec_o,
  input logic [VW-1:0] ppr_o,
  input logic          eoi_bcast_o,
  input logic [N-1:0]  irr_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  tmr_q
);
  p_accept_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_accepted_o |=> irr_q[$past(req_vec_i)] && (tmr_q[$past(req_vec_i)] == $past(req_level_i)));

  p_coalesce_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && irr_q[req_vec_i]) |-> !req_accepted_o);

  p_ppr_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o >= tpr_o);

  p_deliver_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> ((irq_vec_o & 8'hF0) > ppr_o));

  p_ack_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_valid_o) |=> isr_q[$past(irq_vec_o)] && !irr_q[$past(irq_vec_o)]);

  p_eoi_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && isr_q == '0) |=> !eoi_bcast_o);

  p_bcast_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_o |-> $past(eoi_i) && !$past(directed_eoi_i));

  p_alias_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpr_alias_wr_i && !tpr_wr_i) |=> tpr_o[3:0] == 4'h0);

  p_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !req_accepted_o && !irq_valid_o);

  p_ack_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_valid_o && !eoi_i) |=> $stable(isr_q));
endmodule

bind ipac_ctrl ipac_ctrl_chk #(.VW(VW), .N(N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i),
  .req_valid_i(req_valid_i), .req_vec_i(req_vec_i), .req_level_i(req_level_i),
  .req_accepted_o(req_accepted_o), .tpr_wr_i(tpr_wr_i),
  .tpr_alias_wr_i(tpr_alias_wr_i), .tpr_o(tpr_o), .ack_i(ack_i), .eoi_i(eoi_i),
  .directed_eoi_i(directed_eoi_i), .irq_valid_o(irq_valid_o),
  .irq_vec_o(irq_vec_o), .ppr_o(ppr_o), .eoi_bcast_o(eoi_bcast_o),
  .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q));

// File: tb/ipac_ctrl_test.sv
module ipac_ctrl_test;
  localparam int CLK_P = 10;

  // {vec[8], level, tpr[8], exp_acc, exp_valid, exp_vec[8]}
  localparam logic [26:0] TBL [6] = '{
    {8'h35, 1'b0, 8'h00, 1'b1, 1'b1, 8'h35},
    {8'h52, 1'b1, 8'h00, 1'b1, 1'b1, 8'h52},
    {8'h52, 1'b0, 8'h00, 1'b0, 1'b1, 8'h52},
    {8'h40, 1'b0, 8'h50, 1'b1, 1'b0, 8'h00},
    {8'h61, 1'b0, 8'h5F, 1'b1, 1'b1, 8'h61},
    {8'h20, 1'b0, 8'h60, 1'b1, 1'b0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1, req_valid = 1'b0, req_level = 1'b0;
  logic [7:0] req_vec = '0;
  logic tpr_wr = 1'b0, alias_wr = 1'b0, ack = 1'b0, eoi = 1'b0, directed = 1'b0;
  logic [31:0] tpr_data = '0;
  logic [3:0] alias_val = '0;
  logic req_acc, irq_valid, eoi_bcast, eoi_level;
  logic [7:0] tpr, irq_vec, ppr, eoi_vec;
  logic [3:0] tpr_class;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ipac_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .req_valid_i(req_valid), .req_vec_i(req_vec), .req_level_i(req_level),
    .req_accepted_o(req_acc), .tpr_wr_i(tpr_wr), .tpr_data_i(tpr_data),
    .tpr_alias_wr_i(alias_wr), .tpr_alias_i(alias_val), .tpr_o(tpr),
    .tpr_class_o(tpr_class), .ack_i(ack), .eoi_i(eoi), .directed_eoi_i(directed),
    .irq_valid_o(irq_valid), .irq_vec_o(irq_vec), .ppr_o(ppr),
    .eoi_bcast_o(eoi_bcast), .eoi_vec_o(eoi_vec), .eoi_level_o(eoi_level));

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic pulse_eoi(input logic dir);
    directed = dir; eoi = 1'b1; step(); eoi = 1'b0; directed = 1'b0;
  endtask

  task automatic write_tpr(input logic [31:0] d);
    tpr_data = d; tpr_wr = 1'b1; step(); tpr_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset irq_valid", irq_valid, 0);
    chk("R9 reset ppr", ppr, 0);
    chk("R9 reset tpr", tpr, 0);
    rst_n = 1'b1;
    step();

    // Table walk: R1 R2 R3 R4
    for (int i = 0; i < 6; i++) begin
      logic [26:0] e;
      e = TBL[i];
      req_vec = e[26:19]; req_level = e[18];
      tpr_data = {24'h0, e[17:10]}; tpr_wr = 1'b1; req_valid = 1'b1;
      #1;
      chk($sformatf("R1/R2 accept row %0d", i), req_acc, e[9]);
      step();
      req_valid = 1'b0; tpr_wr = 1'b0;
      chk($sformatf("R4 valid row %0d", i), irq_valid, e[8]);
      if (e[8]) chk($sformatf("R4 vec row %0d", i), irq_vec, e[7:0]);
      chk($sformatf("R3 ppr row %0d", i), ppr, e[17:10]);
    end

    write_tpr(32'h0);
    chk("R4 highest pending", irq_vec, 8'h61);
    pulse_ack();
    chk("R5 ppr after ack", ppr, 8'h60);
    chk("R4 gated by in-service class", irq_valid, 0);
    write_tpr(32'h70);
    chk("R3 tpr class wins", ppr, 8'h70);
    write_tpr(32'h0);
    chk("R3 isr class wins", ppr, 8'h60);
    pulse_ack();
    chk("R11 ack idle ppr", ppr, 8'h60);
    chk("R11 ack idle valid", irq_valid, 0);

    pulse_eoi(1'b0);
    chk("R7 bcast", eoi_bcast, 1);
    chk("R7 bcast vec", eoi_vec, 8'h61);
    chk("R7 bcast edge", eoi_level, 0);
    chk("R6 ppr after eoi", ppr, 8'h00);
    chk("R4 next candidate", irq_vec, 8'h52);
    step();
    chk("R7 bcast one cycle", eoi_bcast, 0);

    pulse_ack();
    chk("R5 ppr 0x50", ppr, 8'h50);
    chk("R4 0x40 not above 0x50", irq_valid, 0);
    pulse_eoi(1'b0);
    chk("R7 bcast vec 52", eoi_vec, 8'h52);
    chk("R1 level kept despite coalesced edge (R2)", eoi_level, 1);
    chk("R4 candidate 40", irq_vec, 8'h40);

    pulse_ack();
    chk("R5 ppr 0x40", ppr, 8'h40);
    pulse_eoi(1'b1);
    chk("R7 directed suppresses", eoi_bcast, 0);
    chk("R6 ppr cleared", ppr, 8'h00);
    chk("R4 candidate 35", irq_vec, 8'h35);
    pulse_eoi(1'b0);
    chk("R6 empty eoi no bcast", eoi_bcast, 0);
    chk("R6 empty eoi ppr", ppr, 8'h00);

    // R10: request and ack in one cycle
    req_vec = 8'h90; req_level = 1'b0; req_valid = 1'b1; ack = 1'b1;
    #1;
    chk("R10 accept", req_acc, 1);
    step();
    req_valid = 1'b0; ack = 1'b0;
    chk("R10 ack took old candidate", ppr, 8'h30);
    chk("R10 new request deliverable", irq_vec, 8'h90);
    chk("R10 valid", irq_valid, 1);

    write_tpr(32'h1234_56A7);
    chk("R8 low byte kept", tpr, 8'hA7);
    chk("R8 class", tpr_class, 4'hA);
    chk("R8 ppr", ppr, 8'hA7);
    chk("R4 gated by tpr", irq_valid, 0);
    alias_val = 4'h3; alias_wr = 1'b1; step(); alias_wr = 1'b0;
    chk("R8 alias", tpr, 8'h30);
    chk("R8 alias ppr", ppr, 8'h30);
    chk("R8 alias unlock", irq_valid, 1);

    enable = 1'b0;
    #1;
    chk("R9 disabled no delivery", irq_valid, 0);
    req_vec = 8'hC0; req_valid = 1'b1;
    #1;
    chk("R9 disabled drop", req_acc, 0);
    step();
    req_valid = 1'b0; enable = 1'b1;
    #1;
    chk("R9 dropped not pending", irq_vec, 8'h90);

    rst_n = 1'b0;
    step();
    chk("R9 reset valid", irq_valid, 0);
    chk("R9 reset tpr", tpr, 0);
    chk("R9 reset ppr", ppr, 0);
    rst_n = 1'b1;
    step();
    pulse_eoi(1'b0);
    chk("R9 reset cleared in-service", eoi_bcast, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule